// File: doc/BRIEF.md
# Token-Arbitrated Interprocessor Link Port

This block joins two processors over one byte-wide data bus that both directions share. A single ownership token moves between the two ends. Only the end that holds the token drives the bus. The token moves over a request line and an acknowledge line. Each byte crosses under a strobe/ready handshake. On the local side the block offers a 32-bit word interface. Words written by local logic go into an eight-deep outbound FIFO. Words that arrive from the peer are reassembled and placed in an eight-deep inbound FIFO. Fill levels and full/empty flags for both FIFOs are visible to local logic.

When the outbound FIFO holds a word and this end has the token, the transmitter pops the word and sends it as four bytes, least significant first. When this end lacks the token and has data, it raises request. The holder finishes any word in flight, raises acknowledge and stops driving the bus. The requester then takes ownership, and both lines fall back. Two writes to the flush input on consecutive cycles empty both FIFOs and drop any partly assembled inbound word. A flush leaves the link lines and the token where they were.

The token state machine has four states. TK_IDLE moves to TK_ASK when there is data to send. TK_ASK moves to TK_HOLD when the peer acknowledges. TK_HOLD moves to TK_GRANT when the peer requests and the transmitter is idle. TK_GRANT moves to TK_IDLE when the peer drops its request. The transmitter moves TX_IDLE to TX_STROBE to TX_RELEASE and back to TX_STROBE for each byte, and returns to TX_IDLE after the fourth byte. The receiver alternates between RX_WAIT and RX_HOLD.

Top module: `tlink_port`

## Requirements
- R1: After reset both FIFOs are empty with level 0, strobe, ready, request and acknowledge are low, and only the end built with HOLD_AT_RESET=1 drives the bus (lnk_d_oe=1).
- R2: Each word leaves as four bytes with bits 7:0 first and bits 31:24 last. The peer rebuilds the word, and words come out of its inbound FIFO in the order they were written.
- R3: lnk_d_oe is high only while this end holds the token, the two ends never drive the bus together, and strobe is raised only while driving.
- R4: Once raised, strobe stays high until ready arrives. Ready rises only in answer to a strobe.
- R5: An end without the token that has data raises request. The holder raises acknowledge and releases the bus, and the requester becomes the holder. Words then flow in both directions.
- R6: The holder never raises acknowledge in the middle of a word. The number of bytes sent on the link is a multiple of four whenever acknowledge rises.
- R7: While the inbound FIFO is full, ready stays low and the sender stalls with strobe held high.
- R8: out_level and in_level count the stored words (0 to 8), and full and empty reflect them. A write to a full outbound FIFO is dropped.
- R9: flush_wr high on two consecutive cycles empties both FIFOs of this end by the next cycle. A single-cycle flush_wr changes nothing.
- R10: A flush leaves token ownership, lnk_d_oe and the strobe of a word in flight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push wr_data into the outbound FIFO |
| wr_data | input | 32 | Word to send |
| rd_en | input | 1 | Pop the inbound FIFO head |
| rd_data | output | 32 | Inbound FIFO head word |
| out_level | output | 4 | Words held in the outbound FIFO |
| out_full | output | 1 | Outbound FIFO full |
| out_empty | output | 1 | Outbound FIFO empty |
| in_level | output | 4 | Words held in the inbound FIFO |
| in_full | output | 1 | Inbound FIFO full |
| in_empty | output | 1 | Inbound FIFO empty |
| flush_wr | input | 1 | Write strobe to the flush register |
| lnk_d_i | input | 8 | Byte seen on the shared bus |
| lnk_d_o | output | 8 | Byte this end would drive |
| lnk_d_oe | output | 1 | Drive enable for the shared bus (token held) |
| lnk_stb_i | input | 1 | Peer data strobe |
| lnk_stb_o | output | 1 | Own data strobe |
| lnk_rdy_i | input | 1 | Peer ready |
| lnk_rdy_o | output | 1 | Own ready |
| lnk_req_i | input | 1 | Peer token request |
| lnk_req_o | output | 1 | Own token request |
| lnk_ack_i | input | 1 | Peer token acknowledge |
| lnk_ack_o | output | 1 | Own token acknowledge |

## Verification
Two ports are wired back to back. Words go one way, then the other way, then both ways at once, with expected values computed from index formulas. A receive byte counter that drifts out of step shows up as a mismatched word at the far read port within one word time, about sixteen cycles. A token state that goes wrong shows up as two drivers on the bus, a release in the middle of a word, or a transfer that never finishes. The bench monitors each of these on every cycle. A wrong FIFO count or a wrong flush decode shows at once on the level outputs, on the cycle after the stimulus.

// File: rtl/tlink_pkg.sv
package tlink_pkg;

    typedef enum logic [1:0] {
        TK_IDLE,
        TK_ASK,
        TK_HOLD,
        TK_GRANT
    } tk_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_STROBE,
        TX_RELEASE
    } tx_state_e;

    typedef enum logic {
        RX_WAIT,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/tlink_fifo.sv
module tlink_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/tlink_token.sv
module tlink_token
    import tlink_pkg::*;
#(
    parameter bit START_OWNER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic peer_req,
    input  logic peer_ack,
    input  logic have_data,
    input  logic tx_idle,
    output logic own,
    output logic req_o,
    output logic ack_o
);

    tk_state_e st_q;
    tk_state_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= START_OWNER ? TK_HOLD : TK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TK_IDLE:  if (have_data)            st_d = TK_ASK;
            TK_ASK:   if (peer_ack)             st_d = TK_HOLD;
            TK_HOLD:  if (peer_req && tx_idle)  st_d = TK_GRANT;
            TK_GRANT: if (!peer_req)            st_d = TK_IDLE;
            default:                            st_d = TK_IDLE;
        endcase
    end

    always_comb begin
        own   = 1'b0;
        req_o = 1'b0;
        ack_o = 1'b0;
        unique case (st_q)
            TK_IDLE:  ;
            TK_ASK:   req_o = 1'b1;
            TK_HOLD:  own   = 1'b1;
            TK_GRANT: ack_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/tlink_tx.sv
module tlink_tx
    import tlink_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own,
    input  logic              peer_req,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    input  logic              rdy_i,
    output logic              pop,
    output logic              stb_o,
    output logic [BYTE_W-1:0] d_o,
    output logic              idle
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    tx_state_e         st_q;
    tx_state_e         st_d;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              start;

    assign start = (st_q == TX_IDLE) && own && !fifo_empty && !peer_req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:    if (start) st_d = TX_STROBE;
            TX_STROBE:  if (rdy_i) st_d = TX_RELEASE;
            TX_RELEASE: if (!rdy_i) st_d = (idx == LAST_IDX) ? TX_IDLE : TX_STROBE;
            default:    st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (start) begin
            shreg <= fifo_head;
            idx   <= '0;
        end else if (st_q == TX_RELEASE && !rdy_i && idx != LAST_IDX) begin
            shreg <= {BYTE_W'(0), shreg[WORD_W-1:BYTE_W]};
            idx   <= idx + 1'b1;
        end
    end

    always_comb begin
        pop   = start;
        d_o   = shreg[BYTE_W-1:0];
        stb_o = 1'b0;
        idle  = 1'b0;
        unique case (st_q)
            TX_IDLE:    idle  = 1'b1;
            TX_STROBE:  stb_o = 1'b1;
            TX_RELEASE: ;
            default:    ;
        endcase
    end

endmodule

// File: rtl/tlink_rx.sv
module tlink_rx
    import tlink_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = WORD_W / BYTE_W,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int ACC_W  = WORD_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              stb_i,
    input  logic [BYTE_W-1:0] d_i,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] word,
    output logic              rdy_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

    rx_state_e        st_q;
    rx_state_e        st_d;
    logic [ACC_W-1:0] acc;
    logic [IDX_W-1:0] cnt;
    logic             take;

    assign take = (st_q == RX_WAIT) && stb_i && !fifo_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RX_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_WAIT: if (take)   st_d = RX_HOLD;
            RX_HOLD: if (!stb_i) st_d = RX_WAIT;
            default:             st_d = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (flush) begin
            cnt <= '0;
        end else if (take) begin
            acc <= {d_i, acc[ACC_W-1:BYTE_W]};
            cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        push  = take && (cnt == LAST_IDX) && !flush;
        word  = {d_i, acc};
        rdy_o = 1'b0;
        unique case (st_q)
            RX_WAIT: ;
            RX_HOLD: rdy_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/tlink_port.sv
module tlink_port
    import tlink_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int BYTE_W        = 8,
    parameter int DEPTH         = 8,
    parameter bit HOLD_AT_RESET = 1'b0,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic [LVL_W-1:0]  out_level,
    output logic              out_full,
    output logic              out_empty,
    output logic [LVL_W-1:0]  in_level,
    output logic              in_full,
    output logic              in_empty,
    input  logic              flush_wr,
    input  logic [BYTE_W-1:0] lnk_d_i,
    output logic [BYTE_W-1:0] lnk_d_o,
    output logic              lnk_d_oe,
    input  logic              lnk_stb_i,
    output logic              lnk_stb_o,
    input  logic              lnk_rdy_i,
    output logic              lnk_rdy_o,
    input  logic              lnk_req_i,
    output logic              lnk_req_o,
    input  logic              lnk_ack_i,
    output logic              lnk_ack_o
);

    logic              flush_prev;
    logic              flush_hit;
    logic              own;
    logic              tx_idle;
    logic              out_pop;
    logic [WORD_W-1:0] out_head;
    logic              in_push;
    logic [WORD_W-1:0] in_word;

    // flush register decode: two back-to-back writes are required
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_prev <= 1'b0;
        end else begin
            flush_prev <= flush_wr;
        end
    end

    assign flush_hit = flush_wr && flush_prev;

    tlink_fifo #(.W(WORD_W), .DEPTH(DEPTH)) out_q_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_hit),
        .push  (wr_en),
        .pop   (out_pop),
        .din   (wr_data),
        .dout  (out_head),
        .count (out_level),
        .full  (out_full),
        .empty (out_empty)
    );

    tlink_fifo #(.W(WORD_W), .DEPTH(DEPTH)) in_q_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_hit),
        .push  (in_push),
        .pop   (rd_en),
        .din   (in_word),
        .dout  (rd_data),
        .count (in_level),
        .full  (in_full),
        .empty (in_empty)
    );

    tlink_token #(.START_OWNER(HOLD_AT_RESET)) token_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .peer_req  (lnk_req_i),
        .peer_ack  (lnk_ack_i),
        .have_data (!out_empty),
        .tx_idle   (tx_idle),
        .own       (own),
        .req_o     (lnk_req_o),
        .ack_o     (lnk_ack_o)
    );

    tlink_tx #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .own        (own),
        .peer_req   (lnk_req_i),
        .fifo_empty (out_empty),
        .fifo_head  (out_head),
        .rdy_i      (lnk_rdy_i),
        .pop        (out_pop),
        .stb_o      (lnk_stb_o),
        .d_o        (lnk_d_o),
        .idle       (tx_idle)
    );

    tlink_rx #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_hit),
        .stb_i     (lnk_stb_i),
        .d_i       (lnk_d_i),
        .fifo_full (in_full),
        .push      (in_push),
        .word      (in_word),
        .rdy_o     (lnk_rdy_o)
    );

    assign lnk_d_oe = own;

endmodule

// File: rtl/tlink_port_chk.sv
module tlink_port_chk #(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             flush_wr,
    input logic [LVL_W-1:0] out_level,
    input logic             out_full,
    input logic [LVL_W-1:0] in_level,
    input logic             in_full,
    input logic             lnk_d_oe,
    input logic             lnk_stb_i,
    input logic             lnk_stb_o,
    input logic             lnk_rdy_i,
    input logic             lnk_rdy_o,
    input logic             lnk_req_o,
    input logic             lnk_ack_o
);

    AST_STB_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_stb_o |-> lnk_d_oe);                                            // R3

    AST_STB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_stb_o && !lnk_rdy_i) |=> lnk_stb_o);                           // R4

    AST_RDY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_rdy_o) |-> $past(lnk_stb_i));                             // R4

    AST_REQ_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_o |-> (!lnk_ack_o && !lnk_d_oe));                           // R5

    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_ack_o) |-> (!lnk_stb_o && !lnk_d_oe));                    // R6

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_rdy_o) |-> !$past(in_full));                              // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && wr_en) |=> (out_level <= $past(out_level)));           // R8

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(in_level) <= DEPTH) && (int'(out_level) <= DEPTH));           // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_wr && $past(flush_wr)) |=> (out_level == '0 && in_level == '0)); // R9

endmodule

bind tlink_port tlink_port_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .flush_wr  (flush_wr),
    .out_level (out_level),
    .out_full  (out_full),
    .in_level  (in_level),
    .in_full   (in_full),
    .lnk_d_oe  (lnk_d_oe),
    .lnk_stb_i (lnk_stb_i),
    .lnk_stb_o (lnk_stb_o),
    .lnk_rdy_i (lnk_rdy_i),
    .lnk_rdy_o (lnk_rdy_o),
    .lnk_req_o (lnk_req_o),
    .lnk_ack_o (lnk_ack_o)
);

// File: tb/tlink_port_tb.sv
module tlink_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic        a_wr_en = 0, b_wr_en = 0, a_rd_en = 0, b_rd_en = 0;
    logic        a_flush = 0, b_flush = 0;
    logic [31:0] a_wr_data = '0, b_wr_data = '0;
    logic [31:0] a_rd_data, b_rd_data;
    logic [3:0]  a_out_level, a_in_level, b_out_level, b_in_level;
    logic        a_out_full, a_out_empty, a_in_full, a_in_empty;
    logic        b_out_full, b_out_empty, b_in_full, b_in_empty;
    logic [7:0]  a_d_o, b_d_o, bus;
    logic        a_oe, b_oe, a_stb, b_stb, a_rdy, b_rdy, a_req, b_req, a_ack, b_ack;

    assign bus = a_oe ? a_d_o : (b_oe ? b_d_o : 8'h00);

    tlink_port #(.HOLD_AT_RESET(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_data(a_wr_data),
        .rd_en(a_rd_en), .rd_data(a_rd_data), .out_level(a_out_level),
        .out_full(a_out_full), .out_empty(a_out_empty), .in_level(a_in_level),
        .in_full(a_in_full), .in_empty(a_in_empty), .flush_wr(a_flush),
        .lnk_d_i(bus), .lnk_d_o(a_d_o), .lnk_d_oe(a_oe),
        .lnk_stb_i(b_stb), .lnk_stb_o(a_stb), .lnk_rdy_i(b_rdy), .lnk_rdy_o(a_rdy),
        .lnk_req_i(b_req), .lnk_req_o(a_req), .lnk_ack_i(b_ack), .lnk_ack_o(a_ack)
    );

    tlink_port #(.HOLD_AT_RESET(1'b0)) peer_i (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_data(b_wr_data),
        .rd_en(b_rd_en), .rd_data(b_rd_data), .out_level(b_out_level),
        .out_full(b_out_full), .out_empty(b_out_empty), .in_level(b_in_level),
        .in_full(b_in_full), .in_empty(b_in_empty), .flush_wr(b_flush),
        .lnk_d_i(bus), .lnk_d_o(b_d_o), .lnk_d_oe(b_oe),
        .lnk_stb_i(a_stb), .lnk_stb_o(b_stb), .lnk_rdy_i(a_rdy), .lnk_rdy_o(b_rdy),
        .lnk_req_i(a_req), .lnk_req_o(b_req), .lnk_ack_i(a_ack), .lnk_ack_o(b_ack)
    );

    function automatic logic [31:0] wa(input int i);
        return 32'h1A2B_3C4D + 32'(i) * 32'h0103_0507;
    endfunction
    function automatic logic [31:0] wb(input int i);
        return 32'hC000_0011 ^ (32'(i) * 32'h0711_0D03);
    endfunction
    function automatic logic [31:0] ws(input int i);
        return 32'h5000_0000 + 32'(i) * 32'h0202_0303;
    endfunction

    // link monitors, sampled away from the active edge
    logic       a_stb_q = 0, b_stb_q = 0, a_ack_q = 0, b_ack_q = 0, a_rdy_q = 0, b_rdy_q = 0;
    int         conflicts = 0, midword = 0, hs_err = 0, bytes_sent = 0, first_n = 0;
    logic [7:0] first_bytes [4];

    always @(negedge clk) begin
        if (rst_n) begin
            if (a_oe && b_oe) conflicts++;
            if (a_stb && !a_stb_q) begin
                bytes_sent++;
                if (first_n < 4) begin
                    first_bytes[first_n] = a_d_o;
                    first_n++;
                end
            end
            if (b_stb && !b_stb_q) bytes_sent++;
            if ((a_ack && !a_ack_q) || (b_ack && !b_ack_q)) begin
                if (bytes_sent % 4 != 0) midword++;
            end
            if (a_stb_q && !b_rdy_q && !a_stb) hs_err++;
            if (b_stb_q && !a_rdy_q && !b_stb) hs_err++;
        end
        a_stb_q = a_stb; b_stb_q = b_stb; a_ack_q = a_ack; b_ack_q = b_ack;
        a_rdy_q = a_rdy; b_rdy_q = b_rdy;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_a(input logic [31:0] d);
        a_wr_en = 1; a_wr_data = d; @(negedge clk); a_wr_en = 0;
    endtask
    task automatic push_b(input logic [31:0] d);
        b_wr_en = 1; b_wr_data = d; @(negedge clk); b_wr_en = 0;
    endtask

    task automatic pop_b(input string tag, input logic [31:0] exp);
        int w = 0;
        while (b_in_empty && w < 3000) begin @(negedge clk); w++; end
        check(tag, b_rd_data, exp);
        b_rd_en = 1; @(negedge clk); b_rd_en = 0;
    endtask
    task automatic pop_a(input string tag, input logic [31:0] exp);
        int w = 0;
        while (a_in_empty && w < 3000) begin @(negedge clk); w++; end
        check(tag, a_rd_data, exp);
        a_rd_en = 1; @(negedge clk); a_rd_en = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog R5 actual=expired expected=run complete");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 holder drives", {30'b0, a_oe, b_oe}, 32'h2);
        check("R1 link lines idle", {24'b0, a_stb, b_stb, a_rdy, b_rdy, a_req, b_req, a_ack, b_ack}, 32'h0);
        check("R1 fifos empty", {a_out_empty, a_in_empty, b_out_empty, b_in_empty}, 32'hF);
        check("R1 levels zero", {a_out_level, a_in_level, b_out_level, b_in_level}, 32'h0);

        // R2 words from holder, byte order and word order
        for (int i = 0; i < 3; i++) push_a(wa(i));
        for (int i = 0; i < 3; i++) pop_b("R2 word order A->B", wa(i));
        for (int k = 0; k < 4; k++) check("R2 lsb-first byte", {24'b0, first_bytes[k]}, {24'b0, wa(0)[8*k +: 8]});

        // R5 token moves to the requester
        for (int i = 0; i < 3; i++) push_b(wb(i));
        for (int i = 0; i < 3; i++) pop_a("R5 word order B->A", wb(i));
        repeat (20) @(negedge clk);
        check("R5 token now at peer", {30'b0, a_oe, b_oe}, 32'h1);

        // R5 both directions busy
        for (int i = 0; i < 4; i++) begin
            a_wr_en = 1; a_wr_data = wa(10 + i);
            b_wr_en = 1; b_wr_data = wb(10 + i);
            @(negedge clk);
        end
        a_wr_en = 0; b_wr_en = 0;
        fork
            for (int i = 0; i < 4; i++) pop_b("R5 mixed A->B", wa(10 + i));
            for (int i = 0; i < 4; i++) pop_a("R5 mixed B->A", wb(10 + i));
        join
        repeat (20) @(negedge clk);

        // R7 / R8 stall: fill peer inbound FIFO and local outbound FIFO
        begin
            int acc = 0;
            while (acc < 17) begin
                if (!a_out_full) begin
                    a_wr_en = 1; a_wr_data = ws(acc); acc++;
                end else begin
                    a_wr_en = 0;
                end
                @(negedge clk);
            end
            a_wr_en = 0;
        end
        repeat (600) @(negedge clk);
        check("R7 peer inbound full", {27'b0, b_in_full, b_in_level}, {27'b0, 1'b1, 4'd8});
        check("R7 ready held low", {31'b0, b_rdy}, 32'h0);
        check("R7 sender strobe held", {31'b0, a_stb}, 32'h1);
        check("R8 outbound full", {27'b0, a_out_full, a_out_level}, {27'b0, 1'b1, 4'd8});
        push_a(32'hDEAD_BEEF);
        check("R8 write to full dropped", {28'b0, a_out_level}, 32'd8);

        // R9 / R10 flush
        b_flush = 1; @(negedge clk); b_flush = 0;
        repeat (3) @(negedge clk);
        check("R9 single flush ignored", {28'b0, b_in_level}, 32'd8);
        a_flush = 1; @(negedge clk); @(negedge clk); a_flush = 0;
        check("R9 double flush empties out", {27'b0, a_out_empty, a_out_level}, {27'b0, 1'b1, 4'd0});
        check("R10 token and strobe kept", {30'b0, a_oe, a_stb}, 32'h3);
        b_flush = 1; @(negedge clk); @(negedge clk); b_flush = 0;
        check("R9 double flush empties in", {28'b0, b_in_level}, 32'd0);
        check("R10 peer pins kept", {29'b0, b_oe, b_req, b_ack}, 32'h0);
        repeat (100) @(negedge clk);
        check("R9 only in-flight word remains", {28'b0, b_in_level}, 32'd1);
        pop_b("R9 in-flight word", ws(8));
        repeat (40) @(negedge clk);
        check("R8 all drained", {30'b0, b_in_empty, a_out_empty}, 32'h3);

        check("R3 no bus conflict", 32'(conflicts), 32'd0);
        check("R6 no mid-word release", 32'(midword), 32'd0);
        check("R4 strobe held until ready", 32'(hs_err), 32'd0);
        finish_run();
    end

endmodule